// File: doc/BRIEF.md
# Serial On-Screen-Display Command Decoder

This block sits behind a three-wire serial port (active-low enable, serial clock, serial data) and turns the byte stream into configuration settings and character writes for an on-screen-display engine. The serial pins are brought into the system clock domain through synchronizer stages. Each group of eight serial clock edges makes one word. A word with its top bit set is an identifier byte: it selects one of eight commands and carries a four-bit parameter. A word with its top bit clear is a data byte for whichever command was selected last.

Command 0 positions the character cursor (row and column). Command 1 enters a streaming character mode in which every data byte becomes one display-memory write at the cursor, after which the cursor moves on. Commands 2 to 7 each own a four-bit register loaded from the identifier byte and a seven-bit register loaded from data bytes; the decoder exports them unchanged to the display logic. Two bits of the command-4 parameter are interpreted here: one requests that display memory be filled with the blank code 0x7F, the other is a software reset that clears every setting and holds it cleared until the enable returns high.

Top module: `osd_cmd_decoder`

## Requirements
- R1: Serial data is captured MSB first on each rising serial clock while the enable is low; the eighth capture completes a word, a word in progress is dropped when the enable goes high, and the outputs reflect a completed word (or an enable rise) at the fourth rising `clk` edge after the serial pin change that caused it.
- R2: A word with bit 7 = 1 stores bits 6:4 as the current command, which stays selected for every following data byte (bit 7 = 0) until another identifier byte is accepted.
- R3: Command 0 loads the cursor row from identifier bits 3:0 and the cursor column from data bits 4:0; a row above 11 or a column above 23 is ignored and leaves the cursor as it was.
- R4: Command 1 stores identifier bit 0 as the attribute; each data byte then drives `mem_we_o` high for exactly one cycle with `mem_data_o` = {attribute, data bits 6:0} and `mem_row_o`/`mem_col_o` equal to the cursor before the write.
- R5: After each character write the column increments; column 23 wraps to column 0 of the next row, and row 11 wraps to row 0.
- R6: Once command 1 is selected, identifier bytes are ignored and every data byte is a character write, until the enable goes high.
- R7: An enable rise selects command 0 and leaves character mode; the cursor and attribute keep their values.
- R8: For commands 2..7 the identifier's bits 3:0 load that command's four-bit output and each data byte's bits 6:0 load its seven-bit output; outputs for other commands are unchanged.
- R9: After `rst_n` all outputs are zero and the current command is 0.
- R10: `erase_req_o` equals bit 2 of the command-4 four-bit register (request to fill display memory with code 0x7F).
- R11: A command-4 identifier with bit 0 = 1 clears every command register, the cursor and the attribute (display off), and all words are then ignored until the enable goes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_en_n | input | 1 | Serial enable, active low |
| ser_clk | input | 1 | Serial clock, data taken on its rising edge |
| ser_dat | input | 1 | Serial data |
| mem_we_o | output | 1 | One-cycle display-memory write strobe |
| mem_row_o | output | 4 | Write row address |
| mem_col_o | output | 5 | Write column address |
| mem_data_o | output | 8 | Write data {attribute, code[6:0]} |
| erase_req_o | output | 1 | Display-memory fill request |
| vert_nib_o | output | 4 | Command 2 parameter nibble |
| vert_dat_o | output | 7 | Command 2 data |
| horz_nib_o | output | 4 | Command 3 parameter nibble |
| horz_dat_o | output | 7 | Command 3 data |
| ctl_nib_o | output | 4 | Command 4 parameter nibble |
| ctl_dat_o | output | 7 | Command 4 data (bit 0 display on) |
| fmt_nib_o | output | 4 | Command 5 parameter nibble |
| fmt_dat_o | output | 7 | Command 5 data |
| sync_nib_o | output | 4 | Command 6 parameter nibble |
| sync_dat_o | output | 7 | Command 6 data |
| port_nib_o | output | 4 | Command 7 parameter nibble |
| port_dat_o | output | 7 | Command 7 data |

## Verification
The hardest situation to reach is an identifier byte arriving while character mode is locked, directly followed by a data byte: only the write strobe and the untouched command registers reveal that the identifier was dropped. The stimulus enters character mode, sends a command-2 identifier with a new nibble and then a data byte, and checks both the resulting write and that the command-2 outputs kept their old value. The software-reset hold is reached the same way, by sending command bytes after the reset identifier but before the enable rises. Cursor wrap at the last column and last row is set up by positioning the cursor at row 11, column 22 first.

// File: rtl/osd_pkg.sv
package osd_pkg;
    localparam int WORD_W  = 8;
    localparam int NIB_W   = 4;
    localparam int DAT_W   = 7;
    localparam int CMD_W   = 3;
    localparam int SLOT_BASE = 2;
    localparam int NSLOT     = 6;

    localparam logic [CMD_W-1:0] CMD_ADDR = 3'd0;
    localparam logic [CMD_W-1:0] CMD_CHAR = 3'd1;
    localparam logic [CMD_W-1:0] CMD_CTL  = 3'd4;

    localparam int CTL_ERASE_BIT = 2;
    localparam int CTL_SRST_BIT  = 0;
    localparam logic [DAT_W-1:0] BLANK_CODE = 7'h7F;
endpackage

// File: rtl/osd_sync.sv
module osd_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2,
    parameter logic [N-1:0] INIT = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] sync_o
);
    logic [N-1:0] pipe_q [STAGES];
    logic [N-1:0] pipe_d [STAGES];

    always_comb begin
        pipe_d[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            pipe_d[i] = pipe_q[i-1];
        end
    end

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) pipe_q[g] <= INIT;
                else        pipe_q[g] <= pipe_d[g];
            end
        end
    endgenerate

    assign sync_o = pipe_q[STAGES-1];
endmodule

// File: rtl/osd_ser_rx.sv
module osd_ser_rx
    import osd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_n_s,
    input  logic              sclk_s,
    input  logic              dat_s,
    output logic              word_v_o,
    output logic [WORD_W-1:0] word_o,
    output logic              en_rise_o
);
    localparam int CNT_W = $clog2(WORD_W);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(WORD_W - 1);

    typedef struct packed {
        logic [WORD_W-2:0] sh;
        logic [CNT_W-1:0]  cnt;
        logic              sclk_p;
        logic              en_p;
        logic              wv;
        logic [WORD_W-1:0] word;
        logic              enr;
    } rx_t;

    rx_t s_d, s_q;

    always_comb begin
        s_d        = s_q;
        s_d.wv     = 1'b0;
        s_d.enr    = en_n_s & ~s_q.en_p;
        s_d.sclk_p = sclk_s;
        s_d.en_p   = en_n_s;
        if (en_n_s) begin
            s_d.cnt = '0;
        end else if (sclk_s && !s_q.sclk_p) begin
            s_d.sh  = {s_q.sh[WORD_W-3:0], dat_s};
            s_d.cnt = s_q.cnt + 1'b1;
            if (s_q.cnt == CNT_LAST) begin
                s_d.wv   = 1'b1;
                s_d.word = {s_q.sh, dat_s};
                s_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q        <= '0;
            s_q.sclk_p <= 1'b1;
            s_q.en_p   <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign word_v_o  = s_q.wv;
    assign word_o    = s_q.word;
    assign en_rise_o = s_q.enr;
endmodule

// File: rtl/osd_cmd_ctrl.sv
module osd_cmd_ctrl
    import osd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 24,
    localparam int ROW_W = $clog2(ROWS),
    localparam int COL_W = $clog2(COLS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              word_v_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              en_rise_i,
    output logic              nib_we_o,
    output logic              dat_we_o,
    output logic [CMD_W-1:0]  idx_o,
    output logic [NIB_W-1:0]  nib_o,
    output logic [DAT_W-1:0]  dat_o,
    output logic              clr_o,
    output logic [CMD_W-1:0]  cur_cmd_o,
    output logic              lock_o,
    output logic              hold_o,
    output logic              mem_we_o,
    output logic [ROW_W-1:0]  mem_row_o,
    output logic [COL_W-1:0]  mem_col_o,
    output logic [WORD_W-1:0] mem_data_o
);
    localparam logic [ROW_W-1:0] ROW_LAST = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_LAST = COL_W'(COLS - 1);

    typedef struct packed {
        logic [CMD_W-1:0]  cmd;
        logic              lock;
        logic              hold;
        logic              attr;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              we;
        logic [ROW_W-1:0]  wrow;
        logic [COL_W-1:0]  wcol;
        logic [WORD_W-1:0] wdata;
    } ctl_t;

    ctl_t s_d, s_q;

    logic              is_first;
    logic [CMD_W-1:0]  id_cmd;
    logic [NIB_W-1:0]  id_nib;

    assign is_first = word_i[WORD_W-1];
    assign id_cmd   = word_i[WORD_W-2 -: CMD_W];
    assign id_nib   = word_i[NIB_W-1:0];

    always_comb begin
        s_d      = s_q;
        s_d.we   = 1'b0;
        nib_we_o = 1'b0;
        dat_we_o = 1'b0;
        clr_o    = 1'b0;
        idx_o    = s_q.cmd;
        nib_o    = id_nib;
        dat_o    = word_i[DAT_W-1:0];

        if (en_rise_i) begin
            s_d.cmd  = CMD_ADDR;
            s_d.lock = 1'b0;
            s_d.hold = 1'b0;
        end else if (word_v_i && !s_q.hold) begin
            if (is_first) begin
                if (!s_q.lock) begin
                    s_d.cmd = id_cmd;
                    idx_o   = id_cmd;
                    case (id_cmd)
                        CMD_ADDR: begin
                            if (int'(id_nib) < ROWS) s_d.row = id_nib[ROW_W-1:0];
                        end
                        CMD_CHAR: begin
                            s_d.attr = word_i[0];
                            s_d.lock = 1'b1;
                        end
                        CMD_CTL: begin
                            if (id_nib[CTL_SRST_BIT]) begin
                                s_d.hold = 1'b1;
                                s_d.row  = '0;
                                s_d.col  = '0;
                                s_d.attr = 1'b0;
                                clr_o    = 1'b1;
                            end else begin
                                nib_we_o = 1'b1;
                            end
                        end
                        default: nib_we_o = 1'b1;
                    endcase
                end
            end else begin
                case (s_q.cmd)
                    CMD_ADDR: begin
                        if (int'(word_i[4:0]) < COLS) s_d.col = word_i[COL_W-1:0];
                    end
                    CMD_CHAR: begin
                        s_d.we    = 1'b1;
                        s_d.wrow  = s_q.row;
                        s_d.wcol  = s_q.col;
                        s_d.wdata = {s_q.attr, word_i[DAT_W-1:0]};
                        if (s_q.col == COL_LAST) begin
                            s_d.col = '0;
                            s_d.row = (s_q.row == ROW_LAST) ? '0 : s_q.row + 1'b1;
                        end else begin
                            s_d.col = s_q.col + 1'b1;
                        end
                    end
                    default: dat_we_o = 1'b1;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cur_cmd_o  = s_q.cmd;
    assign lock_o     = s_q.lock;
    assign hold_o     = s_q.hold;
    assign mem_we_o   = s_q.we;
    assign mem_row_o  = s_q.wrow;
    assign mem_col_o  = s_q.wcol;
    assign mem_data_o = s_q.wdata;
endmodule

// File: rtl/osd_cfg_regs.sv
module osd_cfg_regs
    import osd_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   nib_we_i,
    input  logic                   dat_we_i,
    input  logic [CMD_W-1:0]       idx_i,
    input  logic [NIB_W-1:0]       nib_i,
    input  logic [DAT_W-1:0]       dat_i,
    input  logic                   clr_i,
    output logic [NSLOT*NIB_W-1:0] nib_flat_o,
    output logic [NSLOT*DAT_W-1:0] dat_flat_o
);
    typedef struct packed {
        logic [NSLOT-1:0][NIB_W-1:0] nib;
        logic [NSLOT-1:0][DAT_W-1:0] dat;
    } cfg_t;

    cfg_t s_d, s_q;
    logic [CMD_W-1:0] slot;

    assign slot = idx_i - CMD_W'(SLOT_BASE);

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d = '0;
        end else begin
            for (int k = 0; k < NSLOT; k++) begin
                if (int'(slot) == k) begin
                    if (nib_we_i) s_d.nib[k] = nib_i;
                    if (dat_we_i) s_d.dat[k] = dat_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_out
            assign nib_flat_o[g*NIB_W +: NIB_W] = s_q.nib[g];
            assign dat_flat_o[g*DAT_W +: DAT_W] = s_q.dat[g];
        end
    endgenerate
endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
    import osd_pkg::*;
#(
    parameter int ROWS        = 12,
    parameter int COLS        = 24,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ser_en_n,
    input  logic       ser_clk,
    input  logic       ser_dat,
    output logic       mem_we_o,
    output logic [3:0] mem_row_o,
    output logic [4:0] mem_col_o,
    output logic [7:0] mem_data_o,
    output logic       erase_req_o,
    output logic [3:0] vert_nib_o,
    output logic [6:0] vert_dat_o,
    output logic [3:0] horz_nib_o,
    output logic [6:0] horz_dat_o,
    output logic [3:0] ctl_nib_o,
    output logic [6:0] ctl_dat_o,
    output logic [3:0] fmt_nib_o,
    output logic [6:0] fmt_dat_o,
    output logic [3:0] sync_nib_o,
    output logic [6:0] sync_dat_o,
    output logic [3:0] port_nib_o,
    output logic [6:0] port_dat_o
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);

    logic [2:0]              pins_s;
    logic                    word_v;
    logic [WORD_W-1:0]       word;
    logic                    en_rise;
    logic                    nib_we, dat_we, cfg_clr;
    logic [CMD_W-1:0]        cfg_idx;
    logic [NIB_W-1:0]        cfg_nib;
    logic [DAT_W-1:0]        cfg_dat;
    logic [CMD_W-1:0]        cur_cmd;
    logic                    char_lock;
    logic                    sys_hold;
    logic [NSLOT*NIB_W-1:0]  nib_flat;
    logic [NSLOT*DAT_W-1:0]  dat_flat;

    osd_sync #(.N(3), .STAGES(SYNC_STAGES), .INIT(3'b111)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({ser_en_n, ser_clk, ser_dat}),
        .sync_o  (pins_s)
    );

    osd_ser_rx u_rx (
        .clk       (clk),
        .rst_n     (rst_n),
        .en_n_s    (pins_s[2]),
        .sclk_s    (pins_s[1]),
        .dat_s     (pins_s[0]),
        .word_v_o  (word_v),
        .word_o    (word),
        .en_rise_o (en_rise)
    );

    osd_cmd_ctrl #(.ROWS(ROWS), .COLS(COLS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .word_v_i   (word_v),
        .word_i     (word),
        .en_rise_i  (en_rise),
        .nib_we_o   (nib_we),
        .dat_we_o   (dat_we),
        .idx_o      (cfg_idx),
        .nib_o      (cfg_nib),
        .dat_o      (cfg_dat),
        .clr_o      (cfg_clr),
        .cur_cmd_o  (cur_cmd),
        .lock_o     (char_lock),
        .hold_o     (sys_hold),
        .mem_we_o   (mem_we_o),
        .mem_row_o  (mem_row_o[ROW_W-1:0]),
        .mem_col_o  (mem_col_o[COL_W-1:0]),
        .mem_data_o (mem_data_o)
    );

    osd_cfg_regs u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .nib_we_i   (nib_we),
        .dat_we_i   (dat_we),
        .idx_i      (cfg_idx),
        .nib_i      (cfg_nib),
        .dat_i      (cfg_dat),
        .clr_i      (cfg_clr),
        .nib_flat_o (nib_flat),
        .dat_flat_o (dat_flat)
    );

    assign vert_nib_o = nib_flat[0*NIB_W +: NIB_W];
    assign horz_nib_o = nib_flat[1*NIB_W +: NIB_W];
    assign ctl_nib_o  = nib_flat[2*NIB_W +: NIB_W];
    assign fmt_nib_o  = nib_flat[3*NIB_W +: NIB_W];
    assign sync_nib_o = nib_flat[4*NIB_W +: NIB_W];
    assign port_nib_o = nib_flat[5*NIB_W +: NIB_W];
    assign vert_dat_o = dat_flat[0*DAT_W +: DAT_W];
    assign horz_dat_o = dat_flat[1*DAT_W +: DAT_W];
    assign ctl_dat_o  = dat_flat[2*DAT_W +: DAT_W];
    assign fmt_dat_o  = dat_flat[3*DAT_W +: DAT_W];
    assign sync_dat_o = dat_flat[4*DAT_W +: DAT_W];
    assign port_dat_o = dat_flat[5*DAT_W +: DAT_W];

    assign erase_req_o = ctl_nib_o[CTL_ERASE_BIT];
endmodule

// File: rtl/osd_cmd_decoder_chk.sv
module osd_cmd_decoder_chk
    import osd_pkg::*;
#(
    parameter int ROWS = 12,
    parameter int COLS = 24
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   mem_we_o,
    input logic [3:0]             mem_row_o,
    input logic [4:0]             mem_col_o,
    input logic [CMD_W-1:0]       cur_cmd,
    input logic                   char_lock,
    input logic                   sys_hold,
    input logic                   en_rise,
    input logic [NSLOT*NIB_W-1:0] nib_flat,
    input logic [NSLOT*DAT_W-1:0] dat_flat
);
    AST_WE_FROM_CHAR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> ($past(cur_cmd) == CMD_CHAR)); // R4
    AST_WE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |=> !mem_we_o); // R4
    AST_ADDR_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we_o |-> (int'(mem_row_o) < ROWS && int'(mem_col_o) < COLS)); // R5
    AST_LOCK_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (char_lock && !en_rise) |=> char_lock); // R6
    AST_EN_RISE_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
        en_rise |=> (cur_cmd == CMD_ADDR && !char_lock && !sys_hold)); // R7
    AST_HOLD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        sys_hold |-> (nib_flat == '0 && dat_flat == '0)); // R11
endmodule

bind osd_cmd_decoder osd_cmd_decoder_chk #(.ROWS(ROWS), .COLS(COLS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_we_o  (mem_we_o),
    .mem_row_o (mem_row_o),
    .mem_col_o (mem_col_o),
    .cur_cmd   (cur_cmd),
    .char_lock (char_lock),
    .sys_hold  (sys_hold),
    .en_rise   (en_rise),
    .nib_flat  (nib_flat),
    .dat_flat  (dat_flat)
);

// File: tb/osd_cmd_decoder_tb.sv
`timescale 1ns/1ps
module osd_cmd_decoder_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_en_n = 1'b1, ser_clk = 1'b1, ser_dat = 1'b0;
    logic       mem_we_o, erase_req_o;
    logic [3:0] mem_row_o;
    logic [4:0] mem_col_o;
    logic [7:0] mem_data_o;
    logic [3:0] vert_nib_o, horz_nib_o, ctl_nib_o, fmt_nib_o, sync_nib_o, port_nib_o;
    logic [6:0] vert_dat_o, horz_dat_o, ctl_dat_o, fmt_dat_o, sync_dat_o, port_dat_o;

    always #2.5 clk = ~clk;

    osd_cmd_decoder u_dut (
        .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .mem_we_o(mem_we_o), .mem_row_o(mem_row_o), .mem_col_o(mem_col_o), .mem_data_o(mem_data_o),
        .erase_req_o(erase_req_o),
        .vert_nib_o(vert_nib_o), .vert_dat_o(vert_dat_o), .horz_nib_o(horz_nib_o), .horz_dat_o(horz_dat_o),
        .ctl_nib_o(ctl_nib_o), .ctl_dat_o(ctl_dat_o), .fmt_nib_o(fmt_nib_o), .fmt_dat_o(fmt_dat_o),
        .sync_nib_o(sync_nib_o), .sync_dat_o(sync_dat_o), .port_nib_o(port_nib_o), .port_dat_o(port_dat_o)
    );

    int checks = 0, errors = 0, cycles = 0;
    bit done = 1'b0;

    // behavioural reference model
    int m_cmd = 0, m_lock = 0, m_hold = 0, m_row = 0, m_col = 0, m_attr = 0;
    int m_nib[8], m_dat[8];
    int e_we = 0, e_row = 0, e_col = 0, e_data = 0;
    int lw_row = 0, lw_col = 0, lw_data = 0, n_writes = 0;
    int write_log[$];

    task automatic chk(input int act, input int exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int k = 0; k < 8; k++) begin
            m_nib[k] = 0;
            m_dat[k] = 0;
        end
    endtask

    task automatic model_word(input logic [7:0] b);
        if (m_hold != 0) return;
        if (b[7]) begin
            if (m_lock == 0) begin
                m_cmd = int'(b[6:4]);
                if (m_cmd == 0) begin
                    if (int'(b[3:0]) < 12) m_row = int'(b[3:0]);
                end else if (m_cmd == 1) begin
                    m_attr = int'(b[0]);
                    m_lock = 1;
                end else if (m_cmd == 4 && b[0]) begin
                    m_hold = 1;
                    model_clear();
                    m_row = 0; m_col = 0; m_attr = 0;
                end else begin
                    m_nib[m_cmd] = int'(b[3:0]);
                end
            end
        end else begin
            if (m_cmd == 0) begin
                if (int'(b[4:0]) < 24) m_col = int'(b[4:0]);
            end else if (m_cmd == 1) begin
                e_we = 1;
                e_row = m_row;
                e_col = m_col;
                e_data = m_attr * 128 + int'(b[6:0]);
                write_log.push_back(e_data);
                m_col++;
                if (m_col == 24) begin
                    m_col = 0;
                    m_row = (m_row == 11) ? 0 : m_row + 1;
                end
            end else begin
                m_dat[m_cmd] = int'(b[6:0]);
            end
        end
    endtask

    task automatic model_en_rise();
        m_cmd = 0; m_lock = 0; m_hold = 0;
    endtask

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(int'(mem_we_o), e_we, "R4 mem_we");
            chk(int'(mem_row_o), e_row, "R4 mem_row");
            chk(int'(mem_col_o), e_col, "R4 mem_col");
            chk(int'(mem_data_o), e_data, "R4 mem_data");
            chk(int'(erase_req_o), (m_nib[4] >> 2) & 1, "R10 erase_req");
            chk(int'(vert_nib_o), m_nib[2], "R8 vert_nib");
            chk(int'(vert_dat_o), m_dat[2], "R8 vert_dat");
            chk(int'(horz_nib_o), m_nib[3], "R8 horz_nib");
            chk(int'(horz_dat_o), m_dat[3], "R8 horz_dat");
            chk(int'(ctl_nib_o),  m_nib[4], "R8 ctl_nib");
            chk(int'(ctl_dat_o),  m_dat[4], "R8 ctl_dat");
            chk(int'(fmt_nib_o),  m_nib[5], "R8 fmt_nib");
            chk(int'(fmt_dat_o),  m_dat[5], "R8 fmt_dat");
            chk(int'(sync_nib_o), m_nib[6], "R8 sync_nib");
            chk(int'(sync_dat_o), m_dat[6], "R8 sync_dat");
            chk(int'(port_nib_o), m_nib[7], "R8 port_nib");
            chk(int'(port_dat_o), m_dat[7], "R8 port_dat");
            if (mem_we_o) begin
                lw_row = int'(mem_row_o);
                lw_col = int'(mem_col_o);
                lw_data = int'(mem_data_o);
                n_writes++;
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cycles);
            finish_run();
        end
    end

    // n bits, MSB first; full=1 applies the word to the model at the exact output cycle
    task automatic send_bits(input logic [7:0] b, input int n, input bit full);
        for (int i = 7; i > 7 - n; i--) begin
            ser_clk = 1'b0;
            ser_dat = b[i];
            repeat (4) @(negedge clk);
            ser_clk = 1'b1;
            if (i == 0 && full) begin
                repeat (4) @(posedge clk);
                #1 model_word(b);
                @(posedge clk);
                #1 e_we = 0;
                @(negedge clk);
            end else begin
                repeat (4) @(negedge clk);
            end
        end
    endtask

    task automatic send_word(input logic [7:0] b);
        send_bits(b, 8, 1'b1);
    endtask

    task automatic en_down();
        ser_en_n = 1'b0;
        repeat (6) @(negedge clk);
    endtask

    task automatic en_up();
        ser_en_n = 1'b1;
        repeat (4) @(posedge clk);
        #1 model_en_rise();
        repeat (2) @(negedge clk);
    endtask

    initial begin
        model_clear();
        repeat (4) @(negedge clk);
        // R9 reset state
        chk(int'(mem_we_o), 0, "R9 mem_we after reset");
        chk(int'({vert_nib_o, horz_nib_o, ctl_nib_o, fmt_nib_o, sync_nib_o, port_nib_o}), 0, "R9 nibbles after reset");
        chk(int'({vert_dat_o, horz_dat_o, ctl_dat_o}), 0, "R9 data after reset");
        chk(int'({mem_row_o, mem_col_o, mem_data_o, erase_req_o}), 0, "R9 memory port after reset");
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R2 identifier retained over several data bytes
        en_down();
        send_word(8'hA3);
        send_word(8'h15);
        send_word(8'h2A);
        chk(int'(vert_nib_o), 3, "R2 vert nibble");
        chk(int'(vert_dat_o), 8'h2A, "R2 last data byte wins");
        en_up();

        // R1 partial word dropped, MSB-first capture
        en_down();
        send_bits(8'hE0, 3, 1'b0);
        en_up();
        en_down();
        send_word(8'hB9);
        send_word(8'h5A);
        chk(int'(horz_nib_o), 9, "R1 partial word discarded, MSB first");
        chk(int'(horz_dat_o), 8'h5A, "R1 data word");

        // R8 other command registers
        send_word(8'hD6); send_word(8'h33);
        send_word(8'hE5); send_word(8'h71);
        send_word(8'hF3); send_word(8'h0C);
        chk(int'(fmt_nib_o), 6, "R8 fmt nibble");
        chk(int'(sync_dat_o), 8'h71, "R8 sync data");
        chk(int'(port_nib_o), 3, "R8 port nibble");
        chk(int'(vert_nib_o), 3, "R8 untouched command kept");
        en_up();

        // R3 / R4 positioned character write
        en_down();
        send_word(8'h85);
        send_word(8'h0A);
        send_word(8'h91);
        send_word(8'h41);
        chk(lw_row * 256 + lw_col, 5 * 256 + 10, "R3 write address");
        chk(lw_data, 8'hC1, "R4 attribute and code");
        send_word(8'h42);
        chk(lw_col, 11, "R5 column advanced");

        // R6 identifier ignored while locked
        send_word(8'hA7);
        send_word(8'h43);
        chk(lw_data * 256 + lw_col, 8'hC3 * 256 + 12, "R6 data after ignored identifier");
        chk(int'(vert_nib_o), 3, "R6 command 2 unchanged");
        en_up();

        // R7 enable rise returns to command 0
        en_down();
        send_word(8'h03);
        send_word(8'h90);
        send_word(8'h20);
        chk(lw_row * 256 + lw_col, 5 * 256 + 3, "R7 data byte taken as column");
        chk(lw_data, 8'h20, "R7 attribute cleared");
        en_up();

        // R3 out-of-range row and column ignored
        en_down();
        send_word(8'h8C);
        send_word(8'h18);
        send_word(8'h90);
        send_word(8'h7F);
        chk(lw_row * 256 + lw_col, 5 * 256 + 4, "R3 out of range ignored");
        en_up();

        // R5 wrap at last column and last row
        en_down();
        send_word(8'h8B); send_word(8'h16); send_word(8'h90);
        send_word(8'h01); send_word(8'h02);
        chk(lw_row * 256 + lw_col, 11 * 256 + 23, "R5 last column");
        send_word(8'h03);
        chk(lw_row * 256 + lw_col, 0, "R5 wrap to row 0 column 0");
        en_up();
        en_down();
        send_word(8'h84); send_word(8'h17); send_word(8'h90);
        send_word(8'h05); send_word(8'h06);
        chk(lw_row * 256 + lw_col, 5 * 256 + 0, "R5 wrap to next row");
        en_up();

        // R10 erase request
        en_down();
        send_word(8'hC4);
        send_word(8'h01);
        chk(int'(erase_req_o), 1, "R10 erase request");
        chk(int'(ctl_dat_o), 1, "R8 display on");

        // R11 software reset and hold
        send_word(8'hC1);
        chk(int'({erase_req_o, ctl_nib_o, ctl_dat_o, horz_nib_o, port_nib_o}), 0, "R11 cleared");
        send_word(8'hA6);
        send_word(8'h11);
        chk(int'(vert_nib_o) * 256 + int'(vert_dat_o), 0, "R11 words ignored while held");
        en_up();
        en_down();
        send_word(8'hA6);
        chk(int'(vert_nib_o), 6, "R11 released on enable rise");
        en_up();

        chk(n_writes, write_log.size(), "R4 number of writes");
        repeat (4) @(negedge clk);
        finish_run();
    end
endmodule